// File: doc/BRIEF.md
# Trigger Validation Controller

This block decides, channel by channel, whether each fast-trigger pulse is kept or thrown away. A channel's trigger first runs through a programmable delay line, so that it can be lined up in time with the validation gates. While the delayed pulse is high, the block checks on every cycle whether all the gates that channel requires are open. When the delayed pulse ends, the channel issues a one-cycle keep strobe or a one-cycle discard strobe.

Two gates can be required. One is a channel-coincidence gate that arrives already formed on an input. The other is an external gate. A rising edge on a single external input opens it, and it stays open for a programmable number of cycles. A channel with neither gate enabled validates every trigger on its own. A channel with both enabled needs both gates open in the same cycle.

A six-bit debug port shows channel-0 internals and two OR summaries. It is driven only when the front-panel enable is set. The gating and validation logic runs the same way whether or not the port is enabled.

Top module: `trig_validator`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `keep_o`, `discard_o` and `dbg_o` are all zero.
- R2: The delayed trigger of a channel equals its `fast_trig` bit from `trig_delay`+1 cycles earlier. `dbg_o[0]` shows the channel-0 delayed trigger one cycle after that, so it lags `fast_trig[0]` by `trig_delay`+2 cycles.
- R3: With both `chan_en[i]` and `ext_en[i]` clear (self mode), every delayed pulse on channel i is kept.
- R4: With `chan_en[i]` set, a delayed pulse is kept only if `chan_gate[i]` is high on at least one cycle while the delayed pulse is high. Otherwise the pulse is discarded.
- R5: When `ext_en[i]` is set, a cycle in which `ext_in` is high after being low on the previous cycle opens channel i's external gate. The gate is open from the next cycle for exactly `gate_width` cycles. A width of 0 opens no gate. With `ext_en[i]` set, a delayed pulse is kept only if it overlaps an open external gate.
- R6: A new rising edge on `ext_in` while the gate is open reloads the full width, so the gate is extended.
- R7: While `ext_en[i]` is clear, channel i's external gate stays closed, whatever `ext_in` does.
- R8: With both enables set, a pulse is kept only if, on some cycle of the delayed pulse, both gates are open at once.
- R9: Exactly one strobe fires per delayed pulse. It is either `keep_o[i]` or `discard_o[i]`, never both. It lasts one cycle and comes in the cycle after the first low cycle of the delayed trigger.
- R10: `dbg_o` is registered, one cycle after its sources. When `fp_en` was low, `dbg_o` is zero. The bits are: 0 = channel-0 delayed trigger, 1 = channel-0 delayed trigger while its required gates are open, 2 = channel-0 external gate, 3 = `chan_gate[0]`, 4 = OR of all `fast_trig` bits, 5 = OR over all channels of the bit-1 condition.
- R11: `fp_en` has no effect on `keep_o` or `discard_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_trig | input | N_CH | Fast-trigger pulse per channel |
| chan_gate | input | N_CH | Channel-coincidence gate per channel |
| chan_en | input | N_CH | Require the channel gate |
| ext_en | input | N_CH | Enable and require the external gate |
| ext_in | input | 1 | External validation pulse |
| trig_delay | input | DLY_W | Trigger delay setting |
| gate_width | input | WID_W | External gate width in cycles |
| fp_en | input | 1 | Debug port enable |
| keep_o | output | N_CH | One-cycle keep strobe per channel |
| discard_o | output | N_CH | One-cycle discard strobe per channel |
| dbg_o | output | 6 | Channel-0 debug signals |

## Verification
The strobe assertions take the delayed trigger to be a clean level that falls at most once per pulse. This always holds, because it is a tapped shift register fed from a synchronous input. The bench drives every input at the falling clock edge, so each value is stable across the next rising edge. In the directed sections it holds the configuration constant while a pulse is in flight. The random section changes configuration and gate levels at any cycle. This exercises mid-pulse changes, which the reference model follows cycle by cycle.

// File: rtl/tv_pkg.sv
package tv_pkg;
    localparam int DBG_W      = 6;
    localparam int DBG_DTRIG  = 0;
    localparam int DBG_VALID  = 1;
    localparam int DBG_EXTG   = 2;
    localparam int DBG_CHANG  = 3;
    localparam int DBG_TRIGOR = 4;
    localparam int DBG_COINC  = 5;

    typedef struct packed {
        logic seen;
        logic dprev;
        logic keep;
        logic disc;
    } judge_t;
endpackage

// File: rtl/tv_delay_line.sv
module tv_delay_line #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [DLY_W-1:0] dly,
    output logic             dout
);
    localparam int DEPTH = 1 << DLY_W;

    typedef struct packed {
        logic [DEPTH-1:0] sr;
    } dl_t;

    dl_t st_d, st_q;

    always_comb begin
        st_d.sr = {st_q.sr[DEPTH-2:0], din};
        dout    = st_q.sr[dly];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tv_ext_gate.sv
module tv_ext_gate #(
    parameter int WID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             en,
    input  logic [WID_W-1:0] width,
    output logic             gate
);
    typedef struct packed {
        logic [WID_W-1:0] cnt;
    } eg_t;

    eg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en)                st_d.cnt = '0;
        else if (rise)          st_d.cnt = width;
        else if (st_q.cnt != 0) st_d.cnt = st_q.cnt - 1'b1;
        gate = (st_q.cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    gate_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && en && width != '0) |=> gate);
    // R7
    gate_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !gate);
endmodule

// File: rtl/tv_judge.sv
module tv_judge
    import tv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dtrig,
    input  logic ext_gate,
    input  logic chan_gate,
    input  logic ext_req,
    input  logic chan_req,
    output logic hit,
    output logic keep,
    output logic discard
);
    judge_t st_d, st_q;
    logic   fall;

    always_comb begin
        hit        = dtrig & (ext_gate | ~ext_req) & (chan_gate | ~chan_req);
        fall       = st_q.dprev & ~dtrig;
        st_d.dprev = dtrig;
        st_d.seen  = fall ? 1'b0 : (st_q.seen | hit);
        st_d.keep  = fall & st_q.seen;
        st_d.disc  = fall & ~st_q.seen;
        keep       = st_q.keep;
        discard    = st_q.disc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9
    strobe_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtrig) |=> (keep || discard));
    // R9
    keep_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        keep |=> !keep);
    // R9
    discard_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        discard |=> !discard);
endmodule

// File: rtl/trig_validator.sv
module trig_validator
    import tv_pkg::*;
#(
    parameter int N_CH  = 16,
    parameter int DLY_W = 8,
    parameter int WID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CH-1:0]  fast_trig,
    input  logic [N_CH-1:0]  chan_gate,
    input  logic [N_CH-1:0]  chan_en,
    input  logic [N_CH-1:0]  ext_en,
    input  logic             ext_in,
    input  logic [DLY_W-1:0] trig_delay,
    input  logic [WID_W-1:0] gate_width,
    input  logic             fp_en,
    output logic [N_CH-1:0]  keep_o,
    output logic [N_CH-1:0]  discard_o,
    output logic [DBG_W-1:0] dbg_o
);
    typedef struct packed {
        logic             ext_q;
        logic [DBG_W-1:0] dbg;
    } top_t;

    top_t            st_d, st_q;
    logic            ext_rise;
    logic [N_CH-1:0] dtrig, xgate, hit;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        tv_delay_line #(.DLY_W(DLY_W)) i_dly (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (fast_trig[g]),
            .dly  (trig_delay),
            .dout (dtrig[g])
        );
        tv_ext_gate #(.WID_W(WID_W)) i_xg (
            .clk  (clk),
            .rst_n(rst_n),
            .rise (ext_rise),
            .en   (ext_en[g]),
            .width(gate_width),
            .gate (xgate[g])
        );
        tv_judge i_jdg (
            .clk      (clk),
            .rst_n    (rst_n),
            .dtrig    (dtrig[g]),
            .ext_gate (xgate[g]),
            .chan_gate(chan_gate[g]),
            .ext_req  (ext_en[g]),
            .chan_req (chan_en[g]),
            .hit      (hit[g]),
            .keep     (keep_o[g]),
            .discard  (discard_o[g])
        );
    end

    always_comb begin
        ext_rise   = ext_in & ~st_q.ext_q;
        st_d.ext_q = ext_in;
        st_d.dbg   = '0;
        if (fp_en) begin
            st_d.dbg[DBG_DTRIG]  = dtrig[0];
            st_d.dbg[DBG_VALID]  = hit[0];
            st_d.dbg[DBG_EXTG]   = xgate[0];
            st_d.dbg[DBG_CHANG]  = chan_gate[0];
            st_d.dbg[DBG_TRIGOR] = |fast_trig;
            st_d.dbg[DBG_COINC]  = |hit;
        end
        dbg_o = st_q.dbg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10
    dbg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fp_en |=> (dbg_o == '0));
    // R9
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (keep_o & discard_o) == '0);
endmodule

// File: tb/test_trig_validator.sv
module test_trig_validator;
    localparam int N     = 16;
    localparam int DLY_W = 8;
    localparam int WID_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N-1:0]     fast_trig = '0;
    logic [N-1:0]     chan_gate = '0;
    logic [N-1:0]     chan_en = '0;
    logic [N-1:0]     ext_en = '0;
    logic             ext_in = 1'b0;
    logic [DLY_W-1:0] trig_delay = '0;
    logic [WID_W-1:0] gate_width = '0;
    logic             fp_en = 1'b0;
    logic [N-1:0]     keep_o, discard_o;
    logic [5:0]       dbg_o;

    always #4 clk = ~clk;

    trig_validator #(.N_CH(N), .DLY_W(DLY_W), .WID_W(WID_W)) i_trig_validator (
        .clk(clk), .rst_n(rst_n), .fast_trig(fast_trig), .chan_gate(chan_gate),
        .chan_en(chan_en), .ext_en(ext_en), .ext_in(ext_in), .trig_delay(trig_delay),
        .gate_width(gate_width), .fp_en(fp_en), .keep_o(keep_o), .discard_o(discard_o),
        .dbg_o(dbg_o)
    );

    int    vectors = 0;
    int    miscompares = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // reference model state
    logic [N-1:0] hist[$];
    int           m_cnt[N];
    bit           m_seen[N];
    bit           m_dprev[N];
    logic [N-1:0] m_keep = '0;
    logic [N-1:0] m_disc = '0;
    logic [5:0]   m_dbg = '0;
    bit           m_extq = 1'b0;

    always @(posedge clk) begin
        bit [N-1:0] dt, gt, ht;
        bit         rise, fall;
        int         d;
        if (!rst_n) begin
            hist.delete();
            for (int i = 0; i < N; i++) begin
                m_cnt[i] = 0; m_seen[i] = 0; m_dprev[i] = 0;
            end
            m_keep = '0; m_disc = '0; m_dbg = '0; m_extq = 0;
        end else begin
            d = int'(trig_delay);
            rise = ext_in && !m_extq;
            for (int i = 0; i < N; i++) begin
                dt[i] = (hist.size() > d) ? hist[d][i] : 1'b0;
                gt[i] = (m_cnt[i] != 0);
                ht[i] = dt[i] && (gt[i] || !ext_en[i]) && (chan_gate[i] || !chan_en[i]);
            end
            m_dbg = fp_en ? {|ht, |fast_trig, chan_gate[0], gt[0], ht[0], dt[0]} : 6'd0;
            for (int i = 0; i < N; i++) begin
                fall = m_dprev[i] && !dt[i];
                m_keep[i] = fall && m_seen[i];
                m_disc[i] = fall && !m_seen[i];
                m_seen[i] = fall ? 1'b0 : (m_seen[i] || ht[i]);
                m_dprev[i] = dt[i];
                if (!ext_en[i]) m_cnt[i] = 0;
                else if (rise) m_cnt[i] = int'(gate_width);
                else if (m_cnt[i] > 0) m_cnt[i] = m_cnt[i] - 1;
            end
            hist.push_front(fast_trig);
            if (hist.size() > 256) void'(hist.pop_back());
            m_extq = ext_in;
        end
    end

    // per-cycle comparison and channel-0 event counters
    int n_keep0 = 0, n_disc0 = 0, n_extg = 0, n_dbgnz = 0;
    always @(negedge clk) begin
        cycles++;
        vectors++;
        if (keep_o !== m_keep || discard_o !== m_disc) begin
            miscompares++;
            $display("FAIL %s strobes: actual keep=%h disc=%h expected keep=%h disc=%h",
                     cur_req, keep_o, discard_o, m_keep, m_disc);
        end
        vectors++;
        if (dbg_o !== m_dbg) begin
            miscompares++;
            $display("FAIL R10 dbg: actual=%b expected=%b (phase %s)", dbg_o, m_dbg, cur_req);
        end
        if (keep_o[0]) n_keep0++;
        if (discard_o[0]) n_disc0++;
        if (dbg_o[2]) n_extg++;
        if (dbg_o != 0) n_dbgnz++;
    end

    task automatic dchk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // trigger on ch0 of length len, optional ext pulse in same first cycle
    task automatic pulse0(input int len, input bit with_ext);
        @(negedge clk);
        fast_trig = 'b1;
        ext_in = with_ext;
        @(negedge clk);
        ext_in = 1'b0;
        repeat (len - 1) @(negedge clk);
        fast_trig = '0;
    endtask

    task automatic ext_pulse();
        @(negedge clk); ext_in = 1'b1;
        @(negedge clk); ext_in = 1'b0;
    endtask

    int bk, bd, be, bz;
    task automatic base();
        bk = n_keep0; bd = n_disc0; be = n_extg; bz = n_dbgnz;
    endtask

    initial begin
        // watchdog
        fork
            begin
                wait (cycles > 150000);
                miscompares++;
                $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
                $finish;
            end
        join_none

        idle(3);
        dchk("R1", "keep in reset", int'(keep_o), 0);
        dchk("R1", "dbg in reset", int'(dbg_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        dchk("R1", "discard after reset", int'(discard_o), 0);

        // R2 R3: self mode, delay tap observed on dbg bit 0
        cur_req = "R2 R3";
        fp_en = 1'b1; trig_delay = 8'd5;
        base();
        pulse0(3, 0); idle(4);
        dchk("R2", "dbg0 delayed", int'(dbg_o[0]), 1);
        idle(10);
        pulse0(1, 0); idle(12);
        pulse0(5, 0); idle(14);
        dchk("R3", "self keeps ch0", n_keep0 - bk, 3);
        dchk("R9", "self discards ch0", n_disc0 - bd, 0);

        // R4 channel gate
        cur_req = "R4";
        chan_en = '1; trig_delay = 8'd10;
        chan_gate = '1; base();
        pulse0(2, 0); idle(16);
        dchk("R4", "keep with gate", n_keep0 - bk, 1);
        chan_gate = '0; base();
        pulse0(2, 0); idle(16);
        dchk("R4", "discard without gate", n_disc0 - bd, 1);
        chan_en = '0;

        // R5 external gate
        cur_req = "R5";
        ext_en = '1; trig_delay = 8'd3; gate_width = 8'd4;
        base();
        pulse0(1, 1); idle(12);
        dchk("R5", "keep inside gate", n_keep0 - bk, 1);
        base();
        ext_pulse(); idle(1); pulse0(1, 0); idle(12);
        dchk("R5", "discard after gate", n_disc0 - bd, 1);
        gate_width = 8'd0; base();
        pulse0(1, 1); idle(12);
        dchk("R5", "width zero discards", n_disc0 - bd, 1);

        // R6 restart
        cur_req = "R6";
        gate_width = 8'd4; trig_delay = 8'd0; base();
        ext_pulse(); idle(1); ext_pulse(); pulse0(1, 0); idle(8);
        dchk("R6", "extended gate keeps", n_keep0 - bk, 1);

        // R7 gate disabled
        cur_req = "R7";
        ext_en = '0; base();
        ext_pulse(); idle(2); ext_pulse(); pulse0(2, 0); idle(8);
        dchk("R7", "ext gate stays low", n_extg - be, 0);
        dchk("R7", "self keep w/o gate", n_keep0 - bk, 1);

        // R8 combined
        cur_req = "R8";
        ext_en = '1; chan_en = '1; trig_delay = 8'd3; chan_gate = '0; base();
        pulse0(1, 1); idle(12);
        dchk("R8", "only ext open discards", n_disc0 - bd, 1);
        chan_gate = '1; base();
        pulse0(1, 1); idle(12);
        dchk("R8", "both open keeps", n_keep0 - bk, 1);

        // R10 R11 debug disabled
        cur_req = "R11";
        ext_en = '0; chan_en = '0; fp_en = 1'b0; idle(2); base();
        pulse0(3, 0); idle(10);
        dchk("R10", "dbg silent", n_dbgnz - bz, 0);
        dchk("R11", "keep with fp off", n_keep0 - bk, 1);

        // random mixed traffic
        cur_req = "R9";
        for (int c = 0; c < 6000; c++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) begin
                fast_trig[i] = ($urandom_range(0, 5) == 0);
                chan_gate[i] = ($urandom_range(0, 2) == 0);
            end
            ext_in = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 199) == 0) begin
                chan_en = N'($urandom); ext_en = N'($urandom);
                trig_delay = DLY_W'($urandom_range(0, 40));
                gate_width = WID_W'($urandom_range(0, 12));
                fp_en = 1'($urandom);
            end
        end
        fast_trig = '0; ext_in = 1'b0;
        idle(60);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule